// File: doc/BRIEF.md
# Selective Latency-Speculation Dependence Tracker

This block sits beside an out-of-order issue queue whose scheduler wakes dependants of a variable-latency instruction (a load, for example) as if the short latency will hold. For every such predicted instruction that has not yet been verified, the tracker keeps two bit vectors. One marks every physical register whose value depends on the prediction, directly or through a chain. The other marks every issue-queue entry that holds such a dependant. Each issued instruction is checked against these vectors in the cycle after it issues. If it depends on a pending prediction, it stays hidden in the queue. If it does not, the queue is told to free its entry at once.

When a verification arrives, the tracker finds the prediction by its destination register. On a hit, the prediction's dependants are released and freed, except those that some other pending prediction still holds. On a miss, the tracker returns the prediction's register vector as columns to clear in the wakeup matrix, and its entry vector as entries to make selectable again. Nothing outside that dependence chain is touched. The number of tracking slots is the predicted-issue width times one less than the verification delay. A stall output tells the scheduler to stop issuing predicted instructions when the free slots cannot cover them.

Top module: `spec_dep_tracker`

## Requirements
- R1: After reset, `hold_o`, `rm_o`, `unhide_o` and `clr_cols_o` are all zero and `stall_o` is low.
- R2: A predicted instruction (lane `iss_pred_i` set) takes a free slot whose register vector starts as the one-hot of its destination. A later miss on that prediction sets the bit for that destination register in `clr_cols_o`.
- R3: An issued instruction that depends on no pending prediction shows up as bit `idx` of `rm_o` in the cycle after it is presented. Bit i of `rm_o`, `hold_o` and `unhide_o` stands for queue entry i.
- R4: An issued instruction is dependent when either of its sources is set in a pending register vector. It is then added to that prediction's vectors, and `hold_o` shows its entry from the second cycle after issue onward. Chains of any length are followed, one wave per cycle.
- R5: `hold_o` is the union of the entry vectors of all pending predictions. A slot is released in the cycle after its verification is presented, so its entries leave `hold_o` two cycles after the verification.
- R6: A miss (`vfy_hit_i` low) sets `clr_cols_o` to that prediction's register vector and `unhide_o` to its entry vector, one cycle after the verification. Bit r of `clr_cols_o` stands for physical register r. Dependants of other pending predictions are not affected.
- R7: A hit clears no columns and un-hides nothing. It sets in `rm_o` those entries of the prediction's entry vector that no other pending prediction's entry vector contains.
- R8: `stall_o` is high when the number of free slots is below the predicted instructions awaiting allocation plus `PRED_W`. With the default parameters there are two slots.
- R9: An instruction that depends only on a prediction whose verification is in the same check cycle is removed on a hit. On a miss it is un-hidden and its destination is added to `clr_cols_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_vld_i | input | ISSUE_W | Issue lane carries an instruction |
| iss_pred_i | input | ISSUE_W | Instruction on the lane has a predicted latency |
| iss_idx_i | input | ISSUE_W x IW | Issue-queue entry of each lane |
| iss_dst_i | input | ISSUE_W x RW | Destination physical register of each lane |
| iss_src0_i | input | ISSUE_W x RW | First source register of each lane |
| iss_src1_i | input | ISSUE_W x RW | Second source register of each lane |
| vfy_vld_i | input | 1 | A prediction is being verified |
| vfy_dst_i | input | RW | Destination register naming the verified prediction |
| vfy_hit_i | input | 1 | 1 = predicted latency held, 0 = miss |
| hold_o | output | IQ_DEPTH | Entries kept hidden as dependants |
| rm_o | output | IQ_DEPTH | One-cycle pulse: free these entries |
| unhide_o | output | IQ_DEPTH | One-cycle pulse: make these entries selectable again |
| clr_cols_o | output | NUM_PREGS | One-cycle pulse: mark these registers unavailable |
| stall_o | output | 1 | Stop issuing predicted instructions |

## Verification
The bench follows a two-hop chain. If only direct dependants were tracked, the second-hop entry would be freed instead of held, and the miss would leave its register column set. It runs two predictions with separate chains, misses one and hits the other. A design that merged the vectors would clear or un-hide the other chain's entries. An entry that depends on two predictions is followed through a hit of the first: a design that ignored the sharing would free it too early. The bench also verifies a prediction in the same cycle its dependant is checked, where a wrong design strands the entry in `hold_o` or drops it from the clear. Finally, it fills both slots, so that a wrong free count either misses the stall or keeps it up after a slot is released.

// File: rtl/spec_dep_pkg.sv
// Package: shared defaults and the verify-stage encoding for the
// speculation dependence tracker.
package spec_dep_pkg;
    localparam int DEF_NUM_PREGS = 16;
    localparam int DEF_IQ_DEPTH  = 8;
    localparam int DEF_ISSUE_W   = 2;
    localparam int DEF_PRED_W    = 1;
    localparam int DEF_VER_DELAY = 3;

    // Outcome held in the check stage for one verification.
    typedef enum logic [1:0] {
        VFY_NONE = 2'd0,
        VFY_HIT  = 2'd1,
        VFY_MISS = 2'd2
    } vfy_kind_e;
endpackage

// File: rtl/spec_dep_alloc.sv
// spec_dep_alloc: gives each predicted lane, in lane order, the lowest
// free slot not yet taken this cycle. Lanes left over get nothing.
// Assumes: purely combinational, free_i comes from registered state.
module spec_dep_alloc #(
    parameter int SLOTS   = 2,
    parameter int ISSUE_W = 2,
    parameter int RW      = 4
) (
    input  logic [SLOTS-1:0]                free_i,
    input  logic [ISSUE_W-1:0]              req_i,
    input  logic [ISSUE_W-1:0][RW-1:0]      dst_i,
    output logic [SLOTS-1:0]                grant_o,
    output logic [SLOTS-1:0][RW-1:0]        seed_o
);
    logic [SLOTS-1:0] avail;
    logic             found;

    // Lane-ordered first-fit choice of free slots.
    always_comb begin
        avail   = free_i;
        grant_o = '0;
        seed_o  = '0;
        found   = 1'b0;
        for (int l = 0; l < ISSUE_W; l++) begin
            found = 1'b0;
            if (req_i[l]) begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (!found && avail[s]) begin
                        grant_o[s] = 1'b1;
                        seed_o[s]  = dst_i[l];
                        avail[s]   = 1'b0;
                        found      = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spec_dep_slot.sv
// spec_dep_slot: one pending prediction. It holds a register vector
// (seeded with the prediction's destination) and an entry vector. It
// reports which lanes of the wave under check read a marked register,
// and adds those lanes' destinations and entries at the clock edge.
// Assumes: alloc_i and release_i never coincide (alloc only on a free slot).
module spec_dep_slot #(
    parameter int NUM_PREGS = 16,
    parameter int IQ_DEPTH  = 8,
    parameter int ISSUE_W   = 2,
    parameter int RW        = 4,
    parameter int IW        = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_i,
    input  logic [RW-1:0]                 seed_i,
    input  logic                          release_i,
    input  logic [ISSUE_W-1:0]            lane_vld_i,
    input  logic [ISSUE_W-1:0][RW-1:0]    lane_src0_i,
    input  logic [ISSUE_W-1:0][RW-1:0]    lane_src1_i,
    input  logic [ISSUE_W-1:0][RW-1:0]    lane_dst_i,
    input  logic [ISSUE_W-1:0][IW-1:0]    lane_idx_i,
    output logic                          vld_o,
    output logic [RW-1:0]                 seed_o,
    output logic [NUM_PREGS-1:0]          regs_o,
    output logic [IQ_DEPTH-1:0]           ents_o,
    output logic [ISSUE_W-1:0]            dep_o
);
    localparam logic [NUM_PREGS-1:0] REG_ONE = NUM_PREGS'(1);
    localparam logic [IQ_DEPTH-1:0]  ENT_ONE = IQ_DEPTH'(1);

    logic                 vld_q;
    logic [RW-1:0]        seed_q;
    logic [NUM_PREGS-1:0] regs_q;
    logic [IQ_DEPTH-1:0]  ents_q;
    logic [NUM_PREGS-1:0] add_regs;
    logic [IQ_DEPTH-1:0]  add_ents;

    // Dependence check of the wave under check against this slot.
    always_comb begin
        add_regs = '0;
        add_ents = '0;
        for (int l = 0; l < ISSUE_W; l++) begin
            dep_o[l] = vld_q && lane_vld_i[l] &&
                       (regs_q[lane_src0_i[l]] || regs_q[lane_src1_i[l]]);
            if (dep_o[l]) begin
                add_regs = add_regs | (REG_ONE << lane_dst_i[l]);
                add_ents = add_ents | (ENT_ONE << lane_idx_i[l]);
            end
        end
    end

    // Slot state: clear on release, seed on alloc, grow while pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            seed_q <= '0;
            regs_q <= '0;
            ents_q <= '0;
        end else if (release_i) begin
            vld_q  <= 1'b0;
            regs_q <= '0;
            ents_q <= '0;
        end else if (alloc_i) begin
            vld_q  <= 1'b1;
            seed_q <= seed_i;
            regs_q <= REG_ONE << seed_i;
            ents_q <= '0;
        end else if (vld_q) begin
            regs_q <= regs_q | add_regs;
            ents_q <= ents_q | add_ents;
        end
    end

    assign vld_o  = vld_q;
    assign seed_o = seed_q;
    assign regs_o = regs_q;
    assign ents_o = ents_q;

    // R5: a released slot is empty on the next cycle.
    a_r5_release_empties: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> (!vld_q && ents_q == '0));

    // R2: a new slot holds its destination register.
    a_r2_seeded: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |=> (vld_q && regs_q[$past(seed_i)]));

    // R4: vectors of a pending slot only grow.
    a_r4_grow_only: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !release_i && !alloc_i) |=>
        ((regs_q & $past(regs_q)) == $past(regs_q)));
endmodule

// File: rtl/spec_dep_tracker.sv
// spec_dep_tracker: selective dependence tracking for latency-predicted
// instructions. Issue and verify inputs are registered into a check stage.
// All pulses (rm_o, unhide_o, clr_cols_o) are driven from that stage in
// the cycle after the inputs, and slot state updates at the end of it.
// Assumes: a prediction is named by its destination register, which
// stays unique while it is pending.
module spec_dep_tracker
    import spec_dep_pkg::*;
#(
    parameter int NUM_PREGS = DEF_NUM_PREGS,
    parameter int IQ_DEPTH  = DEF_IQ_DEPTH,
    parameter int ISSUE_W   = DEF_ISSUE_W,
    parameter int PRED_W    = DEF_PRED_W,
    parameter int VER_DELAY = DEF_VER_DELAY,
    localparam int RW       = $clog2(NUM_PREGS),
    localparam int IW       = $clog2(IQ_DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ISSUE_W-1:0]            iss_vld_i,
    input  logic [ISSUE_W-1:0]            iss_pred_i,
    input  logic [ISSUE_W-1:0][IW-1:0]    iss_idx_i,
    input  logic [ISSUE_W-1:0][RW-1:0]    iss_dst_i,
    input  logic [ISSUE_W-1:0][RW-1:0]    iss_src0_i,
    input  logic [ISSUE_W-1:0][RW-1:0]    iss_src1_i,
    input  logic                          vfy_vld_i,
    input  logic [RW-1:0]                 vfy_dst_i,
    input  logic                          vfy_hit_i,
    output logic [IQ_DEPTH-1:0]           hold_o,
    output logic [IQ_DEPTH-1:0]           rm_o,
    output logic [IQ_DEPTH-1:0]           unhide_o,
    output logic [NUM_PREGS-1:0]          clr_cols_o,
    output logic                          stall_o
);
    localparam int SLOTS = PRED_W * (VER_DELAY - 1);
    localparam logic [NUM_PREGS-1:0] REG_ONE = NUM_PREGS'(1);
    localparam logic [IQ_DEPTH-1:0]  ENT_ONE = IQ_DEPTH'(1);

    // Check-stage registers.
    logic [ISSUE_W-1:0]         sv_q, sp_q;
    logic [ISSUE_W-1:0][IW-1:0] sidx_q;
    logic [ISSUE_W-1:0][RW-1:0] sdst_q, ss0_q, ss1_q;
    vfy_kind_e                  vk_q;
    logic [RW-1:0]              vdst_q;

    logic [SLOTS-1:0]                  s_vld, vsel, grant;
    logic [SLOTS-1:0][RW-1:0]          s_seed, g_seed;
    logic [SLOTS-1:0][NUM_PREGS-1:0]   s_regs;
    logic [SLOTS-1:0][IQ_DEPTH-1:0]    s_ents;
    logic [SLOTS-1:0][ISSUE_W-1:0]     s_dep;
    logic [ISSUE_W-1:0]                keep, miss;
    logic [IQ_DEPTH-1:0]               shared;

    // Capture the issued wave and the verification into the check stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_q <= '0; sp_q <= '0; sidx_q <= '0; sdst_q <= '0;
            ss0_q <= '0; ss1_q <= '0; vk_q <= VFY_NONE; vdst_q <= '0;
        end else begin
            sv_q   <= iss_vld_i;
            sp_q   <= iss_pred_i & iss_vld_i;
            sidx_q <= iss_idx_i;
            sdst_q <= iss_dst_i;
            ss0_q  <= iss_src0_i;
            ss1_q  <= iss_src1_i;
            vk_q   <= !vfy_vld_i ? VFY_NONE : (vfy_hit_i ? VFY_HIT : VFY_MISS);
            vdst_q <= vfy_dst_i;
        end
    end

    spec_dep_alloc #(.SLOTS(SLOTS), .ISSUE_W(ISSUE_W), .RW(RW)) u_alloc (
        .free_i (~s_vld),
        .req_i  (sp_q),
        .dst_i  (sdst_q),
        .grant_o(grant),
        .seed_o (g_seed)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Match the verification against this slot's prediction.
        assign vsel[s] = (vk_q != VFY_NONE) && s_vld[s] && (s_seed[s] == vdst_q);

        spec_dep_slot #(
            .NUM_PREGS(NUM_PREGS), .IQ_DEPTH(IQ_DEPTH),
            .ISSUE_W(ISSUE_W), .RW(RW), .IW(IW)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (grant[s]),
            .seed_i     (g_seed[s]),
            .release_i  (vsel[s]),
            .lane_vld_i (sv_q),
            .lane_src0_i(ss0_q),
            .lane_src1_i(ss1_q),
            .lane_dst_i (sdst_q),
            .lane_idx_i (sidx_q),
            .vld_o      (s_vld[s]),
            .seed_o     (s_seed[s]),
            .regs_o     (s_regs[s]),
            .ents_o     (s_ents[s]),
            .dep_o      (s_dep[s])
        );
    end

    // Classify the checked wave and turn verifications into pulses.
    always_comb begin
        rm_o       = '0;
        unhide_o   = '0;
        clr_cols_o = '0;
        hold_o     = '0;
        shared     = '0;
        for (int s = 0; s < SLOTS; s++)
            if (s_vld[s]) hold_o = hold_o | s_ents[s];
        for (int l = 0; l < ISSUE_W; l++) begin
            keep[l] = 1'b0;
            miss[l] = 1'b0;
            for (int s = 0; s < SLOTS; s++) begin
                if (s_dep[s][l]) begin
                    if (!vsel[s]) keep[l] = 1'b1;
                    else if (vk_q == VFY_MISS) miss[l] = 1'b1;
                end
            end
            if (sv_q[l]) begin
                if (miss[l]) begin
                    unhide_o   = unhide_o | (ENT_ONE << sidx_q[l]);
                    clr_cols_o = clr_cols_o | (REG_ONE << sdst_q[l]);
                end else if (!keep[l]) begin
                    rm_o = rm_o | (ENT_ONE << sidx_q[l]);
                end
            end
        end
        for (int s = 0; s < SLOTS; s++) begin
            if (vsel[s]) begin
                if (vk_q == VFY_HIT) begin
                    shared = '0;
                    for (int t = 0; t < SLOTS; t++)
                        if (t != s && s_vld[t] && !vsel[t]) shared = shared | s_ents[t];
                    rm_o = rm_o | (s_ents[s] & ~shared);
                end else begin
                    unhide_o   = unhide_o | s_ents[s];
                    clr_cols_o = clr_cols_o | s_regs[s];
                end
            end
        end
    end

    // Stall when free slots cannot cover waiting and next predictions.
    always_comb begin
        stall_o = ($countones(~s_vld) < ($countones(sp_q) + PRED_W));
    end

    // R6: un-hiding only happens on a miss.
    a_r6_unhide_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (unhide_o != '0) |-> (vk_q == VFY_MISS));

    // R7: a hit never clears a register column.
    a_r7_hit_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (vk_q != VFY_MISS) |-> (clr_cols_o == '0));

    // R8: allocation never lands on a busy slot.
    a_r8_grant_free: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & s_vld) == '0));
endmodule

// File: tb/spec_dep_tracker_bench.sv
`timescale 1ns/1ps
module spec_dep_tracker_bench;
    localparam int NP = 16, IQ = 8, ISW = 2, RW = 4, IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ISW-1:0]         iss_vld, iss_pred;
    logic [ISW-1:0][IW-1:0] iss_idx;
    logic [ISW-1:0][RW-1:0] iss_dst, iss_src0, iss_src1;
    logic                   vfy_vld, vfy_hit;
    logic [RW-1:0]          vfy_dst;
    logic [IQ-1:0]          hold, rm, unhide;
    logic [NP-1:0]          clr;
    logic                   stall;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    spec_dep_tracker u_spec_dep_tracker (
        .clk(clk), .rst_n(rst_n),
        .iss_vld_i(iss_vld), .iss_pred_i(iss_pred), .iss_idx_i(iss_idx),
        .iss_dst_i(iss_dst), .iss_src0_i(iss_src0), .iss_src1_i(iss_src1),
        .vfy_vld_i(vfy_vld), .vfy_dst_i(vfy_dst), .vfy_hit_i(vfy_hit),
        .hold_o(hold), .rm_o(rm), .unhide_o(unhide),
        .clr_cols_o(clr), .stall_o(stall)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        iss_vld = '0; iss_pred = '0; iss_idx = '0; iss_dst = '0;
        iss_src0 = '0; iss_src1 = '0;
        vfy_vld = 1'b0; vfy_dst = '0; vfy_hit = 1'b0;
    endtask

    task automatic lane(input int l, input bit pred, input int idx,
                        input int dst, input int s0, input int s1);
        iss_vld[l]  = 1'b1;
        iss_pred[l] = pred;
        iss_idx[l]  = IW'(idx);
        iss_dst[l]  = RW'(dst);
        iss_src0[l] = RW'(s0);
        iss_src1[l] = RW'(s1);
    endtask

    task automatic verify(input int dst, input bit hit);
        vfy_vld = 1'b1; vfy_dst = RW'(dst); vfy_hit = hit;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 hold", int'(hold), 0);
        chk("R1 rm", int'(rm), 0);
        chk("R1 unhide", int'(unhide), 0);
        chk("R1 clr", int'(clr), 0);
        chk("R1 stall", int'(stall), 0);
    endtask

    task automatic t_independent();
        idle(); lane(0, 0, 3, 5, 1, 2); step();
        chk("R3 independent removed", int'(rm), 'h08);
        chk("R3 not held", int'(hold), 0);
        idle(); step();
    endtask

    task automatic t_chain_miss();
        idle(); lane(0, 1, 1, 4, 0, 0); step();
        chk("R3 predicted instr itself freed", int'(rm), 'h02);
        idle(); lane(0, 0, 2, 6, 4, 0); lane(1, 0, 5, 8, 7, 7); step();
        chk("R3 only independent lane freed", int'(rm), 'h20);
        chk("R4 not yet held", int'(hold), 0);
        idle(); lane(0, 0, 6, 9, 6, 0); step();
        chk("R4 second hop not freed", int'(rm), 0);
        chk("R4 first dependant held", int'(hold), 'h04);
        idle(); step();
        chk("R4 chain held", int'(hold), 'h44);
        verify(4, 0); step();
        chk("R6 R2 miss clears chain and seed", int'(clr), 'h250);
        chk("R6 miss unhides chain", int'(unhide), 'h44);
        idle(); step();
        chk("R5 released after miss", int'(hold), 0);
        chk("R5 pulse ends", int'(clr), 0);
    endtask

    task automatic t_hit();
        idle(); lane(0, 1, 0, 10, 0, 0); step();
        idle(); lane(0, 0, 4, 11, 10, 3); step();
        idle(); step();
        chk("R4 direct dependant held", int'(hold), 'h10);
        verify(10, 1); step();
        chk("R7 hit frees dependant", int'(rm), 'h10);
        chk("R7 hit no clear", int'(clr), 0);
        chk("R7 hit no unhide", int'(unhide), 0);
        idle(); step();
        chk("R5 released after hit", int'(hold), 0);
    endtask

    task automatic t_shared_stall();
        idle(); lane(0, 1, 1, 1, 0, 0); step();
        chk("R8 one slot covers", int'(stall), 0);
        idle(); lane(0, 1, 2, 2, 0, 0); step();
        chk("R8 stall when slots run out", int'(stall), 1);
        idle(); lane(0, 0, 7, 3, 1, 2); step();
        chk("R8 stall while full", int'(stall), 1);
        idle(); step();
        chk("R4 shared entry held", int'(hold), 'h80);
        verify(1, 1); step();
        chk("R7 shared entry kept on first hit", int'(rm), 0);
        idle(); step();
        chk("R7 still held by other", int'(hold), 'h80);
        chk("R8 stall drops after release", int'(stall), 0);
        verify(2, 1); step();
        chk("R7 freed on last hit", int'(rm), 'h80);
        idle(); step();
    endtask

    task automatic t_selective();
        idle(); lane(0, 1, 1, 1, 0, 0); step();
        idle(); lane(0, 1, 4, 4, 0, 0); step();
        idle(); lane(0, 0, 2, 3, 1, 0); lane(1, 0, 5, 6, 4, 0); step();
        idle(); step();
        chk("R4 two chains held", int'(hold), 'h24);
        verify(1, 0); step();
        chk("R6 clear limited to missed chain", int'(clr), 'h0A);
        chk("R6 unhide limited to missed chain", int'(unhide), 'h04);
        idle(); step();
        chk("R6 other chain still held", int'(hold), 'h20);
        verify(4, 1); step();
        chk("R7 other chain freed", int'(rm), 'h20);
        idle(); step();
    endtask

    task automatic t_same_cycle();
        idle(); lane(0, 1, 0, 8, 0, 0); step();
        idle(); step();
        idle(); lane(0, 0, 3, 7, 8, 0); verify(8, 1); step();
        chk("R9 dependant freed on same-cycle hit", int'(rm), 'h08);
        idle(); step();
        chk("R9 nothing stranded", int'(hold), 0);
        idle(); lane(0, 1, 0, 8, 0, 0); step();
        idle(); step();
        idle(); lane(0, 0, 3, 7, 8, 0); verify(8, 0); step();
        chk("R9 same-cycle miss unhides", int'(unhide), 'h08);
        chk("R9 same-cycle miss clears", int'(clr), 'h180);
        chk("R9 same-cycle miss not freed", int'(rm), 0);
        idle(); step();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_independent();
        t_chain_miss();
        t_hit();
        t_shared_stall();
        t_selective();
        t_same_cycle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule